// File: doc/BRIEF.md
# Two-Level Turn-Off Sequencer

This block is the digital sequencer behind a gate-driver output stage. It folds a non-inverting command input, an inverting command input and an active-low arm input into one switch request. On a turn-on request it first empties an external timing capacitor for a fixed interval. It then charges the capacitor with a first current and, once a comparator reports the intermediate threshold, with a second current. It enables the gate drive only when a second comparator reports that the clamp voltage has been reached. The length of that whole turn-on cycle is counted in clock quanta and kept as the hold time for the next turn-off.

On turn-off, whether it comes from the command inputs or from a desaturation fault, the block waits a fixed propagation interval. For a fault it waits a longer one instead. It then lowers the gate output until a comparator says the output has crossed the reference level, holds it at that intermediate level for the learned time, and only then switches to the negative rail. No input can skip the intermediate step. Analog parts appear only as comparator inputs and one-hot phase outputs. At the intended 20 MHz clock one count is 50 ns, the discharge interval is 10 counts and the propagation allowance is 4 counts.

Top module: `tlto_seq`

## Requirements
- R1: A request exists only while `cmd_p`=1, `cmd_n`=0 and `arm_n`=1. This supports a non-inverting use (`cmd_n` tied 0, `cmd_p` switching) and an inverting use (`cmd_p` tied 1, `cmd_n` switching). A request pin change reaches the phase outputs on the third rising clock edge after it, through a two-flop synchronizer. From off, a request enters the discharge phase at that edge.
- R2: During and after reset only `dr_off` is high. At all times exactly one of the seven phase outputs is high.
- R3: The discharge phase lasts exactly `DIS_CYC` cycles (10 by default) and is followed by the first charge phase.
- R4: The first charge phase ends on the edge that samples `cap_mid_cmp` high, entering the second charge phase. That phase ends on the edge that samples `cap_full_cmp` high, entering the on phase.
- R5: Let N be the number of cycles spent in discharge plus both charge phases of a completed turn-on. N saturates at 255 (8-bit count). The stored hold time is N-4, floored at zero. It is replaced only when a turn-on completes.
- R6: A request loss while on keeps `dr_on` high for `PROP_CYC` (4) cycles after synchronization. `dr_drop` then appears on the seventh edge after the pin change.
- R7: A desaturation fault while on keeps `dr_on` high for `DESAT_CYC` (8) cycles after synchronization, so `dr_drop` appears on the eleventh edge. If request loss and fault are seen in the same cycle, the request-loss delay applies.
- R8: The drop phase ends on the edge that samples `gate_low_cmp` high. The hold phase then lasts max(H,1) cycles for stored hold time H, and is followed by off.
- R9: Losing the request during discharge or charging returns to off on the third edge, without enabling the drive.
- R10: Request changes and faults during the delay, drop and hold phases have no effect. A request present when off is reached starts discharge on the next edge.
- R11: The desaturation input has no effect while the block is off.
- R12: Off is entered only from hold or from an aborted turn-on. No input path bypasses the intermediate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (20 MHz intended) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_p | input | 1 | Non-inverting command input |
| cmd_n | input | 1 | Inverting command input |
| arm_n | input | 1 | Active-low arm; low forces a turn-off |
| desat_flt | input | 1 | Desaturation fault indication |
| cap_mid_cmp | input | 1 | Timing capacitor passed intermediate threshold |
| cap_full_cmp | input | 1 | Timing capacitor reached clamp voltage |
| gate_low_cmp | input | 1 | Gate output below reference level |
| dr_off | output | 1 | Output at negative rail |
| dr_dis | output | 1 | Capacitor discharge enabled |
| dr_chg1 | output | 1 | First charge current enabled |
| dr_chg2 | output | 1 | Second charge current enabled |
| dr_on | output | 1 | Gate drive on |
| dr_drop | output | 1 | Output falling toward intermediate level |
| dr_hold | output | 1 | Output held at intermediate level |

## Verification
The assertions assume the three comparator inputs are already synchronous to `clk`. They also assume each comparator is meaningful only in its own phase: the capacitor comparators while charging and the gate comparator while dropping. Timing parameters are taken to be at least 1. The stimulus changes every input at falling clock edges only. It raises `cap_mid_cmp`, `cap_full_cmp` and `gate_low_cmp` only after the matching phase output has been seen, and clears them once that phase is left, so the comparator assumptions always hold.

// File: rtl/tlto_pkg.sv
package tlto_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_DIS  = 3'd1,
        ST_CHG1 = 3'd2,
        ST_CHG2 = 3'd3,
        ST_ON   = 3'd4,
        ST_WAIT = 3'd5,
        ST_DROP = 3'd6,
        ST_HOLD = 3'd7
    } tlto_state_e;

    typedef struct packed {
        logic hold;
        logic drop;
        logic on;
        logic chg2;
        logic chg1;
        logic dis;
        logic off;
    } tlto_drive_t;

    // The delay phase keeps the gate driven, so it maps onto the on indicator.
    function automatic tlto_drive_t drive_of(tlto_state_e s);
        tlto_drive_t d;
        d = '0;
        unique case (s)
            ST_OFF:  d.off  = 1'b1;
            ST_DIS:  d.dis  = 1'b1;
            ST_CHG1: d.chg1 = 1'b1;
            ST_CHG2: d.chg2 = 1'b1;
            ST_ON:   d.on   = 1'b1;
            ST_WAIT: d.on   = 1'b1;
            ST_DROP: d.drop = 1'b1;
            ST_HOLD: d.hold = 1'b1;
            default: d.off  = 1'b1;
        endcase
        return d;
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tlto_sync.sv
module tlto_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/tlto_meter.sv
module tlto_meter #(
    parameter int CNT_W    = 8,
    parameter int PROP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             measuring,
    input  logic             capture,
    output logic [CNT_W-1:0] hold_q
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [CNT_W-1:0] PROP = CNT_W'(PROP_CYC);

    logic [CNT_W-1:0] meas;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] hold_d;

    // The capture cycle itself belongs to the measured interval.
    always_comb begin
        total  = (meas == CMAX) ? CMAX : meas + 1'b1;
        hold_d = (total > PROP) ? total - PROP : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meas <= '0;
        end else if (measuring) begin
            meas <= total;
        end else begin
            meas <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (capture) begin
            hold_q <= hold_d;
        end
    end

    // R5: the interval count sticks at its ceiling while measuring
    a_r5_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (measuring && meas == CMAX) |=> (meas == CMAX || !measuring));

    // R5: the learned hold time only moves when a turn-on completes
    a_r5_hold_kept: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(hold_q));

endmodule

// File: rtl/tlto_fsm.sv
module tlto_fsm
    import tlto_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DIS_CYC   = 10,
    parameter int PROP_CYC  = 4,
    parameter int DESAT_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             flt,
    input  logic             cap_mid,
    input  logic             cap_full,
    input  logic             gate_low,
    input  logic [CNT_W-1:0] hold_q,
    output tlto_state_e      state,
    output logic             measuring,
    output logic             capture
);
    localparam int BIG   = max_int(DIS_CYC, DESAT_CYC);
    localparam int NEED  = $clog2(BIG + 1);
    localparam int TMR_W = max_int(NEED, CNT_W);

    tlto_state_e      nxt;
    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] tmr_n;

    always_comb begin
        nxt   = state;
        tmr_n = tmr;
        unique case (state)
            ST_OFF: begin
                if (req) begin
                    nxt   = ST_DIS;
                    tmr_n = '0;
                end
            end
            ST_DIS: begin
                if (!req) begin
                    nxt = ST_OFF;
                end else if (tmr == TMR_W'(DIS_CYC - 1)) begin
                    nxt = ST_CHG1;
                end else begin
                    tmr_n = tmr + 1'b1;
                end
            end
            ST_CHG1: begin
                if (!req)         nxt = ST_OFF;
                else if (cap_mid) nxt = ST_CHG2;
            end
            ST_CHG2: begin
                if (!req)          nxt = ST_OFF;
                else if (cap_full) nxt = ST_ON;
            end
            ST_ON: begin
                // logic turn-off wins over a simultaneous fault
                if (!req) begin
                    nxt   = ST_WAIT;
                    tmr_n = TMR_W'(PROP_CYC - 1);
                end else if (flt) begin
                    nxt   = ST_WAIT;
                    tmr_n = TMR_W'(DESAT_CYC - 1);
                end
            end
            ST_WAIT: begin
                if (tmr == '0) nxt = ST_DROP;
                else           tmr_n = tmr - 1'b1;
            end
            ST_DROP: begin
                if (gate_low) begin
                    nxt   = ST_HOLD;
                    tmr_n = TMR_W'(hold_q);
                end
            end
            ST_HOLD: begin
                if (tmr <= TMR_W'(1)) nxt = ST_OFF;
                else                  tmr_n = tmr - 1'b1;
            end
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            state <= nxt;
            tmr   <= tmr_n;
        end
    end

    assign measuring = (state == ST_DIS) || (state == ST_CHG1) || (state == ST_CHG2);
    assign capture   = (state == ST_CHG2) && req && cap_full;

    // Independent run-length counter used only to check the discharge window.
    logic [TMR_W-1:0] dis_seen;
    always_ff @(posedge clk) begin
        if (rst)                  dis_seen <= '0;
        else if (state == ST_DIS) dis_seen <= dis_seen + 1'b1;
        else                      dis_seen <= '0;
    end

    // R3: the first charge phase starts only after a full discharge window
    a_r3_discharge_len: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHG1 && $past(state) == ST_DIS) |-> ($past(dis_seen) == TMR_W'(DIS_CYC - 1)));

    // R8: the hold phase is entered only from drop with the gate below reference
    a_r8_hold_entry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) != ST_HOLD) |-> ($past(state) == ST_DROP && $past(gate_low)));

endmodule

// File: rtl/tlto_seq.sv
module tlto_seq
    import tlto_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIS_CYC     = 10,
    parameter int PROP_CYC    = 4,
    parameter int DESAT_CYC   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_p,
    input  logic cmd_n,
    input  logic arm_n,
    input  logic desat_flt,
    input  logic cap_mid_cmp,
    input  logic cap_full_cmp,
    input  logic gate_low_cmp,
    output logic dr_off,
    output logic dr_dis,
    output logic dr_chg1,
    output logic dr_chg2,
    output logic dr_on,
    output logic dr_drop,
    output logic dr_hold
);
    logic             req_raw;
    logic [1:0]       sync_q;
    logic             req;
    logic             flt;
    tlto_state_e      state;
    logic             measuring;
    logic             capture;
    logic [CNT_W-1:0] hold_q;
    tlto_drive_t      drv;

    assign req_raw = cmd_p & ~cmd_n & arm_n;

    tlto_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({req_raw, desat_flt}),
        .q   (sync_q)
    );

    assign req = sync_q[1];
    assign flt = sync_q[0];

    tlto_fsm #(
        .CNT_W     (CNT_W),
        .DIS_CYC   (DIS_CYC),
        .PROP_CYC  (PROP_CYC),
        .DESAT_CYC (DESAT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .flt       (flt),
        .cap_mid   (cap_mid_cmp),
        .cap_full  (cap_full_cmp),
        .gate_low  (gate_low_cmp),
        .hold_q    (hold_q),
        .state     (state),
        .measuring (measuring),
        .capture   (capture)
    );

    tlto_meter #(
        .CNT_W    (CNT_W),
        .PROP_CYC (PROP_CYC)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .measuring (measuring),
        .capture   (capture),
        .hold_q    (hold_q)
    );

    assign drv     = drive_of(state);
    assign dr_off  = drv.off;
    assign dr_dis  = drv.dis;
    assign dr_chg1 = drv.chg1;
    assign dr_chg2 = drv.chg2;
    assign dr_on   = drv.on;
    assign dr_drop = drv.drop;
    assign dr_hold = drv.hold;

    // R2: exactly one phase indicator is active
    a_r2_one_phase: assert property (@(posedge clk) disable iff (rst)
        $countones({dr_off, dr_dis, dr_chg1, dr_chg2, dr_on, dr_drop, dr_hold}) == 1);

    // R4: the drive turns on only out of the second charge phase at clamp
    a_r4_on_after_clamp: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_on) |-> ($past(dr_chg2) && $past(cap_full_cmp)));

    // R12: the rail is reached only through hold or an aborted turn-on
    a_r12_no_bypass: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_off) |-> ($past(dr_hold) || $past(dr_dis) || $past(dr_chg1) || $past(dr_chg2)));

    // R10: once dropping or holding, only the rail can follow
    a_r10_turnoff_locked: assert property (@(posedge clk) disable iff (rst)
        (dr_drop || dr_hold) |=> (dr_drop || dr_hold || dr_off));

endmodule

// File: tb/tlto_seq_test.sv
module tlto_seq_test;
    localparam int DIS   = 10;
    localparam int PROP  = 4;
    localparam int DSAT  = 8;
    localparam int S_OFF  = 0;
    localparam int S_DIS  = 1;
    localparam int S_CHG1 = 2;
    localparam int S_CHG2 = 3;
    localparam int S_ON   = 4;
    localparam int S_DROP = 5;
    localparam int S_HOLD = 6;

    logic clk = 1'b0;
    logic rst;
    logic cmd_p, cmd_n, arm_n, desat_flt, cap_mid, cap_full, gate_low;
    logic dr_off, dr_dis, dr_chg1, dr_chg2, dr_on, dr_drop, dr_hold;
    logic [6:0] st;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tlto_seq #(
        .CNT_W(8), .SYNC_STAGES(2), .DIS_CYC(DIS), .PROP_CYC(PROP), .DESAT_CYC(DSAT)
    ) uut (
        .clk(clk), .rst(rst), .cmd_p(cmd_p), .cmd_n(cmd_n), .arm_n(arm_n),
        .desat_flt(desat_flt), .cap_mid_cmp(cap_mid), .cap_full_cmp(cap_full),
        .gate_low_cmp(gate_low), .dr_off(dr_off), .dr_dis(dr_dis), .dr_chg1(dr_chg1),
        .dr_chg2(dr_chg2), .dr_on(dr_on), .dr_drop(dr_drop), .dr_hold(dr_hold)
    );

    assign st = {dr_hold, dr_drop, dr_on, dr_chg2, dr_chg1, dr_dis, dr_off};

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_hold_len(int n);
        int s;
        int h;
        s = (n > 255) ? 255 : n;
        h = (s > PROP) ? s - PROP : 0;
        return (h < 1) ? 1 : h;
    endfunction

    task automatic set_idle(input bit inv);
        cmd_p = inv;
        cmd_n = inv;
    endtask

    task automatic set_req();
        cmd_p = 1'b1;
        cmd_n = 1'b0;
        arm_n = 1'b1;
    endtask

    // offm: 0 release command, 1 arm low, 2 fault, 3 fault plus release
    task automatic run(input bit inv, input int t1, input int t2, input int t3,
                       input int offm, input bit rr);
        int k, dc, c1, c2, d, h, nn, ek;
        bit on_ok;
        set_req();
        k = 0;
        do begin @(negedge clk); k++; end while (!st[S_DIS] && k < 20);
        chk("R1 request to discharge edges", k, 3);
        dc = 0;
        while (st[S_DIS] && dc < 1000) begin dc++; @(negedge clk); end
        chk("R3 discharge length", dc, DIS);
        c1 = 0;
        while (st[S_CHG1] && c1 < 1000) begin
            if (c1 == t1) cap_mid = 1'b1;
            c1++; @(negedge clk);
        end
        chk("R4 first charge length", c1, t1 + 1);
        c2 = 0;
        while (st[S_CHG2] && c2 < 1000) begin
            if (c2 == t2) cap_full = 1'b1;
            c2++; @(negedge clk);
        end
        chk("R4 second charge length", c2, t2 + 1);
        chk("R4 drive on after clamp", st, 1 << S_ON);
        cap_mid = 1'b0;
        cap_full = 1'b0;
        nn = dc + c1 + c2;
        repeat (2) @(negedge clk);
        case (offm)
            0: set_idle(inv);
            1: arm_n = 1'b0;
            2: desat_flt = 1'b1;
            default: begin desat_flt = 1'b1; set_idle(inv); end
        endcase
        ek = (offm == 2) ? 3 + DSAT : 3 + PROP;
        k = 0;
        on_ok = 1'b1;
        do begin
            @(negedge clk); k++;
            if (!st[S_DROP] && st != (1 << S_ON)) on_ok = 1'b0;
        end while (!st[S_DROP] && k < 100);
        chk((offm == 2) ? "R7 fault to drop edges" : "R6 logic off to drop edges", k, ek);
        chk("R6 drive kept on during delay", on_ok, 1);
        d = 0;
        while (st[S_DROP] && d < 1000) begin
            if (d == t3) gate_low = 1'b1;
            d++; @(negedge clk);
        end
        chk("R8 drop length", d, t3 + 1);
        chk("R8 hold follows drop", st, 1 << S_HOLD);
        desat_flt = 1'b0;
        arm_n = 1'b1;
        if (rr) set_req(); else set_idle(inv);
        h = 0;
        while (st[S_HOLD] && h < 1000) begin h++; @(negedge clk); end
        chk("R5 hold length from learned time", h, exp_hold_len(nn));
        gate_low = 1'b0;
        chk("R8 rail after hold", st, 1 << S_OFF);
        if (rr) begin
            @(negedge clk);
            chk("R10 pending request starts discharge", st, 1 << S_DIS);
            set_idle(inv);
            k = 0;
            do begin @(negedge clk); k++; end while (!st[S_OFF] && k < 20);
            chk("R9 abort during discharge edges", k, 3);
        end else begin
            repeat (4) @(negedge clk);
            chk("R10 stays off without request", st, 1 << S_OFF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int t1s[3];
        int t2s[3];
        int big[4];
        rst = 1'b1;
        cmd_p = 1'b0; cmd_n = 1'b0; arm_n = 1'b1; desat_flt = 1'b0;
        cap_mid = 1'b0; cap_full = 1'b0; gate_low = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 reset state", st, 1 << S_OFF);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 idle after reset", st, 1 << S_OFF);

        desat_flt = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R11 fault ignored while off", st, 1 << S_OFF);
        end
        desat_flt = 1'b0;

        // R1: every pin combination other than the request one leaves the block off
        for (int c = 0; c < 8; c++) begin
            if (c != 3'b101) begin
                cmd_p = c[2]; cmd_n = c[1]; arm_n = c[0];
                repeat (5) @(negedge clk);
                chk("R1 no request combination", st, 1 << S_OFF);
            end
        end
        cmd_p = 1'b0; cmd_n = 1'b0; arm_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: abort in charge phase
        set_req();
        while (!st[S_CHG1]) @(negedge clk);
        set_idle(1'b0);
        n = 0;
        do begin @(negedge clk); n++; end while (!st[S_OFF] && n < 20);
        chk("R9 abort during charge edges", n, 3);
        repeat (4) @(negedge clk);

        t1s = '{0, 3, 9};
        t2s = '{0, 4, 17};
        n = 0;
        for (int i = 0; i < 3; i++) begin
            for (int j = 0; j < 3; j++) begin
                run(n[0], t1s[i], t2s[j], n % 5, n % 4, (n % 3) == 0);
                n++;
            end
        end
        // R5 saturation boundaries: N = 252, 255, 256, 262
        big = '{240, 243, 244, 250};
        for (int b = 0; b < 4; b++) begin
            run(b[0], 0, big[b], 1, b, b[0]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule